// File: doc/BRIEF.md
# Way-Partitioned Reconfigurable Cache Lookup

This block is the tag and lookup engine of a small four-way set-associative cache. Software can switch its ways on or off, or hand them to different requesters, through a configuration word. A request carries a byte address and a 2-bit requester number. The engine splits the address into a tag, a set index and a byte offset. It then compares the tag only in the ways that are enabled and owned by that requester. The hit or miss result appears one cycle after the request is accepted.

On a miss, the engine asks lower memory for the whole line and waits for the line to arrive. It then installs the line in a round-robin victim chosen among the requester's ways. If the requester owns no enabled way, the access is served uncached and nothing is installed. With one configuration word, the array can act as a four-way cache, a two-way cache, a direct-mapped cache, or a set of isolated way groups.

Changing the ownership or enable state of a way starts a scrub. The scrub walks every set, one per clock, and invalidates the lines held in each changed way before new lookups are allowed.

Top module: `wpart_cache`

## Requirements
- R1: Address bits [3:0] are the byte offset and are ignored for matching. Bits [6:4] select one of 8 sets, and bits [31:7] form the tag. `lkp_valid` is high exactly in the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge).
- R2: `lkp_hit` is high only when a way is enabled, is owned by the request's requester, holds a valid line and holds a tag equal to the address tag. `lkp_way` then names that way and `lkp_data` gives its stored word. A line installed for one requester never hits for another requester.
- R3: After a miss, `refill_req` stays high with `refill_addr` equal to the request address with bits [3:0] cleared, until `refill_valid` is seen. In the next cycle, `fill_done` pulses for one cycle and `fill_data` carries the word that was accepted.
- R4: Each set keeps a 2-bit pointer, reset to 0. The victim is the first way, starting at the pointer and counting upward modulo 4, that is enabled and owned by the requester. After the fill, the pointer becomes victim+1 modulo 4. `fill_way` reports the victim, and a later request for the installed line hits in that way.
- R5: A miss by a requester that owns no enabled way still performs the refill handshake. `fill_alloc` is 0 and no line is installed.
- R6: The configuration word holds one enable bit per way in `cfg_way_en[w]` and a 2-bit owner in `cfg_way_owner[2w+1:2w]`. A write (`cfg_we`) is taken only when the engine is idle, meaning no lookup, refill or scrub is in progress; at other times it is ignored. While `cfg_we` is high, `req_ready` is low, so a write wins over a request in the same cycle.
- R7: A taken write that changes the enable bit or the owner of any way starts a scrub. The scrub clears the valid bits of exactly those ways in sets 0 to 7, in order, one set per cycle. `busy` is high for 8 cycles and `scrub_done` is high in the last of them. A write that changes nothing starts no scrub. Lines in unchanged ways survive.
- R8: While `busy` is high, `req_ready` is low and no request is accepted.
- R9: After reset, every line is invalid, all four ways are enabled and owned by requester 0, and `busy`, `lkp_valid`, `refill_req` and `fill_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_way_en | input | 4 | Per-way enable bits |
| cfg_way_owner | input | 8 | Per-way 2-bit owner requester |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 32 | Request byte address |
| req_id | input | 2 | Requester number |
| lkp_valid | output | 1 | Lookup result valid |
| lkp_hit | output | 1 | Lookup hit |
| lkp_way | output | 2 | Way that hit |
| lkp_data | output | 32 | Stored word of the hit line |
| refill_req | output | 1 | Line fetch request to lower memory |
| refill_addr | output | 32 | Line address of the fetch |
| refill_valid | input | 1 | Lower memory returns the line |
| refill_data | input | 32 | Returned line word |
| fill_done | output | 1 | Miss completed |
| fill_alloc | output | 1 | Line was installed |
| fill_way | output | 2 | Way that received the line |
| fill_data | output | 32 | Word delivered for the miss |
| busy | output | 1 | Scrub in progress |
| scrub_done | output | 1 | Last set of the scrub processed |

## Verification
The lookup is exercised with several address patterns. Repeated line addresses with different offsets show that the offset is ignored. Addresses with the same tag in different sets separate the index from the tag. Five tags in one set force the round-robin victim to wrap and evict the oldest line. The same addresses are then replayed under different way-ownership patterns: two requesters splitting the ways, a requester with no ways, direct-mapped and all-disabled. These runs tell apart isolation, uncached service and per-way scrubbing. Configuration writes are also issued during a refill, in the same cycle as a request, and with unchanged values. These show when a write is dropped, when it takes priority, and when it costs no scrub.

// File: rtl/wpart_pkg.sv
package wpart_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 4;
    localparam int IDX_W  = 3;
    localparam int WAYS   = 4;
    localparam int ID_W   = 2;
    localparam int DATA_W = 32;

    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL
    } ctl_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } line_addr_t;

    typedef struct packed {
        logic             alloc;
        logic [WAY_W-1:0] way;
        logic [DATA_W-1:0] data;
    } fill_result_t;

    function automatic logic [WAY_W-1:0] way_after(input logic [WAY_W-1:0] w);
        return WAY_W'(int'(w) + 1);
    endfunction
endpackage

// File: rtl/wpart_tag_match.sv
module wpart_tag_match
    import wpart_pkg::*;
(
    input  logic [WAYS-1:0]            way_en,
    input  logic [WAYS-1:0][ID_W-1:0]  way_owner,
    input  logic [ID_W-1:0]            id,
    input  logic [WAYS-1:0]            row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            owned,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign owned[w] = way_en[w] && (way_owner[w] == id);
        assign match[w] = owned[w] && row_valid[w] && (row_tag[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/wpart_victim_pick.sv
module wpart_victim_pick
    import wpart_pkg::*;
(
    input  logic [WAYS-1:0]  mask,
    input  logic [WAY_W-1:0] start,
    output logic             any,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        victim = start;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (mask[WAY_W'(int'(start) + k)]) victim = WAY_W'(int'(start) + k);
        end
    end

    assign any = |mask;
endmodule

// File: rtl/wpart_scrub_walk.sv
module wpart_scrub_walk
    import wpart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WAYS-1:0]  start_mask,
    output logic             active,
    output logic [IDX_W-1:0] set_idx,
    output logic [WAYS-1:0]  clear_mask,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            set_idx    <= '0;
            clear_mask <= '0;
        end else if (start) begin
            active     <= 1'b1;
            set_idx    <= '0;
            clear_mask <= start_mask;
        end else if (active) begin
            if (set_idx == IDX_W'(SETS - 1)) active <= 1'b0;
            else set_idx <= set_idx + 1'b1;
        end
    end

    assign done = active && (set_idx == IDX_W'(SETS - 1));
endmodule

// File: rtl/wpart_cache.sv
module wpart_cache
    import wpart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WAYS-1:0]   cfg_way_en,
    input  logic [WAYS*ID_W-1:0] cfg_way_owner,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    output logic              lkp_valid,
    output logic              lkp_hit,
    output logic [WAY_W-1:0]  lkp_way,
    output logic [DATA_W-1:0] lkp_data,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    input  logic              refill_valid,
    input  logic [DATA_W-1:0] refill_data,
    output logic              fill_done,
    output logic              fill_alloc,
    output logic [WAY_W-1:0]  fill_way,
    output logic [DATA_W-1:0] fill_data,
    output logic              busy,
    output logic              scrub_done
);
    ctl_state_e st_q;

    logic [WAYS-1:0]           en_q;
    logic [WAYS-1:0][ID_W-1:0] own_q;
    line_addr_t                line_q;
    logic [ID_W-1:0]           id_q;

    logic [WAYS-1:0]             vld_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
    logic [WAYS-1:0][DATA_W-1:0] dat_q [SETS];
    logic [WAY_W-1:0]            rr_q  [SETS];

    fill_result_t fres_q;
    logic         fdone_q;

    logic             scr_active;
    logic [IDX_W-1:0] scr_set;
    logic [WAYS-1:0]  scr_clear;
    logic             scr_start;
    logic [WAYS-1:0]  cfg_change;

    logic [WAYS-1:0]  owned;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             vic_any;
    logic [WAY_W-1:0] vic_way;

    logic idle, cfg_take, accept, fill_take;
    logic unused_offset;

    assign unused_offset = ^req_addr[OFF_W-1:0];

    assign idle      = (st_q == ST_IDLE) && !scr_active;
    assign cfg_take  = cfg_we && idle;
    assign req_ready = idle && !cfg_we;
    assign accept    = req_valid && req_ready;
    assign fill_take = (st_q == ST_FILL) && refill_valid;

    for (genvar w = 0; w < WAYS; w++) begin : g_chg
        assign cfg_change[w] = (en_q[w] != cfg_way_en[w]) ||
                               (own_q[w] != cfg_way_owner[w*ID_W +: ID_W]);
    end
    assign scr_start = cfg_take && (|cfg_change);

    wpart_tag_match i_match (
        .way_en    (en_q),
        .way_owner (own_q),
        .id        (id_q),
        .row_valid (vld_q[line_q.idx]),
        .row_tag   (tag_q[line_q.idx]),
        .tag       (line_q.tag),
        .owned     (owned),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    wpart_victim_pick i_victim (
        .mask   (owned),
        .start  (rr_q[line_q.idx]),
        .any    (vic_any),
        .victim (vic_way)
    );

    wpart_scrub_walk i_scrub (
        .clk        (clk),
        .rst        (rst),
        .start      (scr_start),
        .start_mask (cfg_change),
        .active     (scr_active),
        .set_idx    (scr_set),
        .clear_mask (scr_clear),
        .done       (scrub_done)
    );

    // control and configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            en_q    <= '1;
            own_q   <= '0;
            line_q  <= '0;
            id_q    <= '0;
            fdone_q <= 1'b0;
            fres_q  <= '0;
        end else begin
            fdone_q <= 1'b0;
            if (cfg_take) begin
                en_q <= cfg_way_en;
                for (int w = 0; w < WAYS; w++) begin
                    own_q[w] <= cfg_way_owner[w*ID_W +: ID_W];
                end
            end
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        line_q <= line_addr_t'(req_addr[ADDR_W-1:OFF_W]);
                        id_q   <= req_id;
                        st_q   <= ST_LOOK;
                    end
                end
                ST_LOOK: st_q <= hit ? ST_IDLE : ST_FILL;
                ST_FILL: begin
                    if (refill_valid) begin
                        fdone_q      <= 1'b1;
                        fres_q.alloc <= vic_any;
                        fres_q.way   <= vic_way;
                        fres_q.data  <= refill_data;
                        st_q         <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // valid bits and replacement pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (scr_active) begin
            vld_q[scr_set] <= vld_q[scr_set] & ~scr_clear;
        end else if (fill_take && vic_any) begin
            vld_q[line_q.idx][vic_way] <= 1'b1;
            rr_q[line_q.idx]           <= way_after(vic_way);
        end
    end

    // tag and data storage
    always_ff @(posedge clk) begin
        if (fill_take && vic_any) begin
            tag_q[line_q.idx][vic_way] <= line_q.tag;
            dat_q[line_q.idx][vic_way] <= refill_data;
        end
    end

    assign lkp_valid   = (st_q == ST_LOOK);
    assign lkp_hit     = lkp_valid && hit;
    assign lkp_way     = hit ? hit_way : '0;
    assign lkp_data    = lkp_hit ? dat_q[line_q.idx][hit_way] : '0;
    assign refill_req  = (st_q == ST_FILL);
    assign refill_addr = {line_q, {OFF_W{1'b0}}};
    assign fill_done   = fdone_q;
    assign fill_alloc  = fres_q.alloc;
    assign fill_way    = fres_q.way;
    assign fill_data   = fres_q.data;
    assign busy        = scr_active;
endmodule

// File: rtl/wpart_cache_chk.sv
module wpart_cache_chk
    import wpart_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      lkp_valid,
    input logic                      lkp_hit,
    input logic [WAY_W-1:0]          lkp_way,
    input logic                      refill_req,
    input logic                      refill_valid,
    input logic                      fill_done,
    input logic                      busy,
    input logic                      scrub_done,
    input logic [WAYS-1:0]           en_q,
    input logic [WAYS-1:0][ID_W-1:0] own_q,
    input logic [ID_W-1:0]           id_q
);
    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> lkp_valid); // R1

    AST_HIT_IN_OWNED_WAY: assert property (@(posedge clk) disable iff (rst)
        lkp_valid && lkp_hit |-> en_q[lkp_way] && (own_q[lkp_way] == id_q)); // R2

    AST_REFILL_HELD: assert property (@(posedge clk) disable iff (rst)
        refill_req && !refill_valid |=> refill_req); // R3

    AST_FILL_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
        refill_req && refill_valid |=> fill_done && !refill_req); // R3

    AST_SCRUB_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        scrub_done |=> !scrub_done && !busy); // R7

    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        scrub_done |-> busy); // R7

    AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready); // R8

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lkp_valid, refill_req, busy})); // R6
endmodule

bind wpart_cache wpart_cache_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .lkp_valid    (lkp_valid),
    .lkp_hit      (lkp_hit),
    .lkp_way      (lkp_way),
    .refill_req   (refill_req),
    .refill_valid (refill_valid),
    .fill_done    (fill_done),
    .busy         (busy),
    .scrub_done   (scrub_done),
    .en_q         (en_q),
    .own_q        (own_q),
    .id_q         (id_q)
);

// File: tb/test_wpart_cache.sv
`timescale 1ns/1ps
module test_wpart_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_way_en = '0;
    logic [7:0]  cfg_way_owner = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_id = '0;
    logic        lkp_valid, lkp_hit;
    logic [1:0]  lkp_way;
    logic [31:0] lkp_data;
    logic        refill_req;
    logic [31:0] refill_addr;
    logic        refill_valid = 1'b0;
    logic [31:0] refill_data = '0;
    logic        fill_done, fill_alloc;
    logic [1:0]  fill_way;
    logic [31:0] fill_data;
    logic        busy, scrub_done;

    always #4 clk = ~clk;

    wpart_cache i_wpart_cache (.*);

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int          ms = 0;        // 0 idle, 1 look, 2 refill, 3 scrub
    logic [27:0] ml = '0;
    logic [1:0]  mid = '0;
    bit          mval [4][8];
    logic [24:0] mtag [4][8];
    logic [31:0] mdat [4][8];
    int          mptr [8];
    bit          men [4];
    logic [1:0]  mown [4];
    int          scnt = 0;
    bit          smask [4];
    bit          mdone = 0;
    bit          mfa = 0;
    int          mfw = 0;
    logic [31:0] mfd = '0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit owns(input int w, input logic [1:0] id);
        return men[w] && (mown[w] == id);
    endfunction

    function automatic bit m_lookup(output int way);
        int idx;
        idx = int'(ml[2:0]);
        way = 0;
        for (int w = 3; w >= 0; w--) begin
            if (owns(w, mid) && mval[w][idx] && mtag[w][idx] == ml[27:3]) begin
                way = w;
                m_lookup = 1'b1;
            end
        end
        if (!(owns(0, mid) && mval[0][idx] && mtag[0][idx] == ml[27:3]) &&
            !(owns(1, mid) && mval[1][idx] && mtag[1][idx] == ml[27:3]) &&
            !(owns(2, mid) && mval[2][idx] && mtag[2][idx] == ml[27:3]) &&
            !(owns(3, mid) && mval[3][idx] && mtag[3][idx] == ml[27:3]))
            m_lookup = 1'b0;
    endfunction

    task automatic cyc(input bit cw, input logic [3:0] cen, input logic [7:0] cown,
                       input bit rv, input logic [31:0] ra, input logic [1:0] rid,
                       input bit fv, input logic [31:0] fd);
        int  hway;
        bit  h;
        bit  chg [4];
        bit  anychg;
        int  idx;
        @(negedge clk);
        cfg_we = cw; cfg_way_en = cen; cfg_way_owner = cown;
        req_valid = rv; req_addr = ra; req_id = rid;
        refill_valid = fv; refill_data = fd;
        #1;
        h = m_lookup(hway);
        chk("R6/R8", "req_ready", 32'(req_ready), 32'((ms == 0) && !cw));
        chk("R7", "busy", 32'(busy), 32'(ms == 3));
        chk("R7", "scrub_done", 32'(scrub_done), 32'((ms == 3) && (scnt == 7)));
        chk("R1", "lkp_valid", 32'(lkp_valid), 32'(ms == 1));
        if (ms == 1) begin
            chk("R2", "lkp_hit", 32'(lkp_hit), 32'(h));
            if (h) begin
                chk("R2", "lkp_way", 32'(lkp_way), 32'(hway));
                chk("R2", "lkp_data", lkp_data, mdat[hway][int'(ml[2:0])]);
            end
        end
        chk("R3", "refill_req", 32'(refill_req), 32'(ms == 2));
        if (ms == 2) chk("R3", "refill_addr", refill_addr, {ml, 4'h0});
        chk("R3", "fill_done", 32'(fill_done), 32'(mdone));
        if (mdone) begin
            chk("R5", "fill_alloc", 32'(fill_alloc), 32'(mfa));
            chk("R3", "fill_data", fill_data, mfd);
            if (mfa) chk("R4", "fill_way", 32'(fill_way), 32'(mfw));
        end
        @(posedge clk);
        mdone = 0;
        idx = int'(ml[2:0]);
        case (ms)
            0: begin
                if (cw) begin
                    anychg = 0;
                    for (int w = 0; w < 4; w++) begin
                        chg[w] = (men[w] != cen[w]) || (mown[w] != cown[2*w +: 2]);
                        anychg |= chg[w];
                        smask[w] = chg[w];
                        men[w] = cen[w];
                        mown[w] = cown[2*w +: 2];
                    end
                    if (anychg) begin ms = 3; scnt = 0; end
                end else if (rv) begin
                    ml = ra[31:4]; mid = rid; ms = 1;
                end
            end
            1: ms = h ? 0 : 2;
            2: begin
                if (fv) begin
                    mfa = 0;
                    for (int k = 3; k >= 0; k--) begin
                        if (owns((mptr[idx] + k) % 4, mid)) begin
                            mfa = 1; mfw = (mptr[idx] + k) % 4;
                        end
                    end
                    if (mfa) begin
                        mval[mfw][idx] = 1; mtag[mfw][idx] = ml[27:3];
                        mdat[mfw][idx] = fd; mptr[idx] = (mfw + 1) % 4;
                    end
                    mfd = fd; mdone = 1; ms = 0;
                end
            end
            default: begin
                for (int w = 0; w < 4; w++) if (smask[w]) mval[w][scnt] = 0;
                if (scnt == 7) ms = 0; else scnt++;
            end
        endcase
    endtask

    task automatic idle();
        cyc(0, 4'h0, 8'h00, 0, 32'h0, 2'd0, 0, 32'h0);
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int off);
        return {25'(tag), 3'(idx), 4'(off)};
    endfunction

    task automatic access(input logic [31:0] a, input logic [1:0] id, input logic [31:0] d,
                          input bit poke, input logic [3:0] pen, input logic [7:0] pown);
        while (ms != 0) idle();
        cyc(0, 4'h0, 8'h00, 1, a, id, 0, 32'h0);
        while (ms != 0) begin
            if (ms == 2) begin
                cyc(poke, pen, pown, 0, 32'h0, 2'd0, 0, 32'h0);   // R3 hold before handshake
                cyc(0, 4'h0, 8'h00, 0, 32'h0, 2'd0, 1, d);
            end else idle();
        end
        idle();
    endtask

    task automatic configure(input logic [3:0] en, input logic [7:0] own);
        while (ms != 0) idle();
        cyc(1, en, own, 0, 32'h0, 2'd0, 0, 32'h0);
        while (ms != 0) idle();
        idle();
    endtask

    initial begin
        for (int w = 0; w < 4; w++) begin
            men[w] = 1; mown[w] = 2'd0; smask[w] = 0;
            for (int s = 0; s < 8; s++) begin mval[w][s] = 0; mtag[w][s] = '0; mdat[w][s] = '0; end
        end
        for (int s = 0; s < 8; s++) mptr[s] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9", "busy after reset", 32'(busy), 32'h0);
        chk("R9", "lkp_valid after reset", 32'(lkp_valid), 32'h0);
        chk("R9", "refill_req after reset", 32'(refill_req), 32'h0);
        chk("R9", "fill_done after reset", 32'(fill_done), 32'h0);
        idle();
        // R4 fills, R1 offset ignored, R2 hit
        access(mk(5, 3, 0), 2'd0, 32'hA5A5_0001, 0, 4'h0, 8'h00);
        access(mk(5, 3, 8), 2'd0, 32'h0, 0, 4'h0, 8'h00);
        access(mk(5, 2, 0), 2'd0, 32'hA5A5_0002, 0, 4'h0, 8'h00);
        access(mk(6, 3, 4), 2'd0, 32'hA5A5_0003, 0, 4'h0, 8'h00);
        access(mk(7, 3, 0), 2'd0, 32'hA5A5_0004, 0, 4'h0, 8'h00);
        access(mk(8, 3, 0), 2'd0, 32'hA5A5_0005, 0, 4'h0, 8'h00);
        access(mk(9, 3, 0), 2'd0, 32'hA5A5_0006, 0, 4'h0, 8'h00);
        access(mk(5, 3, 0), 2'd0, 32'hA5A5_0007, 0, 4'h0, 8'h00);
        access(mk(6, 3, 0), 2'd0, 32'h0, 0, 4'h0, 8'h00);
        // R5 requester without ways
        access(mk(5, 3, 0), 2'd1, 32'hBEEF_0001, 0, 4'h0, 8'h00);
        // R6 write beats request in same cycle, unchanged values start no scrub
        cyc(1, 4'hF, 8'h00, 1, mk(5, 3, 0), 2'd0, 0, 32'h0);
        idle(); idle();
        // R7 split ways: 0,1 to requester 0, 2,3 to requester 1
        configure(4'hF, 8'b0101_0000);
        access(mk(5, 3, 0), 2'd0, 32'h0, 0, 4'h0, 8'h00);
        access(mk(7, 3, 0), 2'd0, 32'hC0DE_0001, 0, 4'h0, 8'h00);
        access(mk(7, 3, 0), 2'd1, 32'hC0DE_0002, 0, 4'h0, 8'h00);
        access(mk(7, 3, 0), 2'd1, 32'h0, 0, 4'h0, 8'h00);
        access(mk(11, 6, 0), 2'd1, 32'hC0DE_0003, 0, 4'h0, 8'h00);
        access(mk(11, 6, 0), 2'd0, 32'hC0DE_0004, 0, 4'h0, 8'h00);
        // R6 write during refill is ignored
        access(mk(12, 1, 0), 2'd0, 32'hD00D_0001, 1, 4'h1, 8'h00);
        access(mk(5, 3, 0), 2'd0, 32'h0, 0, 4'h0, 8'h00);
        // direct-mapped mode: only way 0
        configure(4'h1, 8'h00);
        access(mk(13, 4, 0), 2'd0, 32'hE000_0001, 0, 4'h0, 8'h00);
        access(mk(14, 4, 0), 2'd0, 32'hE000_0002, 0, 4'h0, 8'h00);
        access(mk(13, 4, 0), 2'd0, 32'hE000_0003, 0, 4'h0, 8'h00);
        access(mk(13, 4, 2), 2'd0, 32'h0, 0, 4'h0, 8'h00);
        // R8 request held while scrub runs
        cyc(1, 4'h3, 8'h00, 0, 32'h0, 2'd0, 0, 32'h0);
        while (ms == 3) cyc(0, 4'h0, 8'h00, 1, mk(13, 4, 0), 2'd0, 0, 32'h0);
        while (ms != 0) begin
            if (ms == 2) cyc(0, 4'h0, 8'h00, 0, 32'h0, 2'd0, 1, 32'hF00D_0001);
            else idle();
        end
        idle();
        // all ways off: uncached
        configure(4'h0, 8'h00);
        access(mk(13, 4, 0), 2'd0, 32'hF00D_0002, 0, 4'h0, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule